// File: doc/BRIEF.md
# Self-Starting Pseudorandom Sequence Register

This block produces a pseudorandom bit stream from a shift register whose top stage is fed by the XOR of a fixed set of stage outputs. Each enabled clock moves every stage one place toward stage 0. The new top bit is the XOR of the tap outputs. Stage 0 is the serial output, and the whole register is also visible as a state vector. Three widths are supported: 3, 4 and 16. For each of them the tap set gives a maximal period of 2^WIDTH - 1.

A plain register of this kind stays in the all-zero state for ever once it gets there, for example after power-up or after a zero seed is loaded. This block avoids that. When every stage is zero it forces a 1 into the top stage, so it returns to the maximal cycle by itself, with no external reset. A seed can be loaded at any time, and the load takes priority over the shift for that cycle.

Top module: `sslfsr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the state to the value 1, meaning only stage 0 is set. Reset takes priority over load and enable.
- R2: With `en` high and `load` low, each stage i below the top takes the old value of stage i+1 at the clock edge. `serial_out` always equals stage 0 of `state`.
- R3: The new top bit is the XOR of these taps: stages 0 and 1 for WIDTH 3 and for WIDTH 4, and stages 0, 4, 13 and 15 for WIDTH 16.
- R4: From the all-zero state, an enabled shift puts 1 into the top stage. The next state has only the top bit set (4, 8 and 0x8000 for widths 3, 4 and 16).
- R5: From the all-ones state, an enabled shift puts 0 into the top stage. The next state is all ones shifted right by one.
- R6: With `load` high, the state takes `seed` at the next edge, whatever `en` is. A seed of zero is accepted.
- R7: With `en` and `load` both low, the state holds, including the all-zero state.
- R8: From any nonzero state, enabled shifting never reaches zero and repeats with period 2^WIDTH - 1. For widths 3 and 4, every nonzero state appears exactly once in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Shift enable |
| load | input | 1 | Load `seed` into the register |
| seed | input | WIDTH | Value to load |
| serial_out | output | 1 | Generated bit (stage 0) |
| state | output | WIDTH | Current register contents |

## Verification
The bench forces the register into the all-zero state by loading a zero seed, then shifts. A design without the zero correction would stay at zero for ever. The bench also loads all ones. A correction that inverts the feedback instead of only forcing it in the zero state would put a 1 at the top and produce a different sequence. Periods are measured for all three widths, and the states of the 3- and 4-bit registers are counted. A wrong tap set or shift direction then shows up as a short cycle or a repeated state. Load against enable, and reset against load, are driven together on the same edge, which exposes a design with the wrong priority.

// File: rtl/sslfsr.sv
module sslfsr #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic             serial_out,
  output logic [WIDTH-1:0] state
);

  function automatic logic [WIDTH-1:0] tap_mask();
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (WIDTH == 16) m[i] = (i == 0) || (i == 4) || (i == 13) || (i == 15);
      else             m[i] = (i == 0) || (i == 1);
    end
    return m;
  endfunction

  localparam logic [WIDTH-1:0] TAPS     = tap_mask();
  localparam logic [WIDTH-1:0] START    = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] q;
  logic             is_zero;
  logic             fb;

  assign is_zero    = (q == '0);
  assign fb         = (^(q & TAPS)) | is_zero;
  assign state      = q;
  assign serial_out = q[0];

  always_ff @(posedge clk) begin
    if (rst)       q <= START;
    else if (load) q <= seed;
    else if (en)   q <= {fb, q[WIDTH-1:1]};
  end

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1])); // R2
  AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == '0) |=> state == {1'b1, {(WIDTH-1){1'b0}}}); // R4
  AST_ONES_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == ALL_ONES) |=> !state[WIDTH-1]); // R5
  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state)); // R7
  AST_NO_ZERO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state != '0) |=> state != '0); // R8

endmodule

// File: tb/sslfsr_tb_top.sv
module sslfsr_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [15:0] seed = '0;
  logic s3, s4, s16;
  logic [2:0] q3;
  logic [3:0] q4;
  logic [15:0] q16;

  sslfsr #(.WIDTH(3))  dut3_i (.clk(clk), .rst(rst), .en(en), .load(load), .seed(seed[2:0]), .serial_out(s3),  .state(q3));
  sslfsr #(.WIDTH(4))  dut4_i (.clk(clk), .rst(rst), .en(en), .load(load), .seed(seed[3:0]), .serial_out(s4),  .state(q4));
  sslfsr #(.WIDTH(16)) dut_i  (.clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),      .serial_out(s16), .state(q16));

  typedef struct { int w; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;
  logic [15:0] m3 = 16'd1, m4 = 16'd1, m16 = 16'd1;

  function automatic logic [15:0] model(int w, logic [15:0] s);
    logic [15:0] mask;
    logic nb;
    mask = (16'h1 << w) - 16'h1;
    if (rst)   return 16'd1;
    if (load)  return seed & mask;
    if (!en)   return s;
    if (s == 16'h0) nb = 1'b1;
    else if (w == 16) nb = s[0] ^ s[4] ^ s[13] ^ s[15];
    else nb = s[0] ^ s[1];
    return (s >> 1) | (16'(nb) << (w - 1));
  endfunction

  function automatic string tag_of(int w, logic [15:0] s);
    logic [15:0] mask;
    mask = (16'h1 << w) - 16'h1;
    if (rst)        return "R1";
    if (load)       return "R6";
    if (!en)        return "R7";
    if (s == 16'h0) return "R4";
    if (s == mask)  return "R5";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic e, logic l, logic [15:0] sd);
    string t;
    @(negedge clk);
    rst = r; en = e; load = l; seed = sd;
    t = tag_of(3, m3);  m3  = model(3, m3);   sb.push_back('{3, m3, t});
    t = tag_of(4, m4);  m4  = model(4, m4);   sb.push_back('{4, m4, t});
    t = tag_of(16, m16); m16 = model(16, m16); sb.push_back('{16, m16, t});
    @(posedge clk);
    #4;
  endtask

  always @(posedge clk) begin
    item_t it;
    logic [15:0] act;
    logic sbit;
    #2;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      if (it.w == 3)      begin act = {13'b0, q3}; sbit = s3;  end
      else if (it.w == 4) begin act = {12'b0, q4}; sbit = s4;  end
      else                begin act = q16;         sbit = s16; end
      chk(it.tag, act, it.exp);
      chk("R2 serial", {15'b0, sbit}, {15'b0, it.exp[0]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p3, p4, p16;
    int cnt3 [8];
    int cnt4 [16];
    logic [15:0] h3, h4, h16;
    p3 = 0; p4 = 0; p16 = 0;
    foreach (cnt3[k]) cnt3[k] = 0;
    foreach (cnt4[k]) cnt4[k] = 0;

    step(1, 0, 0, 16'h0);
    step(1, 1, 1, 16'hFFFF);
    chk("R1 reset w16", q16, 16'd1);
    chk("R1 reset w3", {13'b0, q3}, 16'd1);

    for (int i = 1; i <= 65535; i++) begin
      step(0, 1, 0, 16'h0);
      if (i <= 7)  cnt3[q3]++;
      if (i <= 15) cnt4[q4]++;
      if (q3 == 3'd1 && p3 == 0) p3 = i;
      if (q4 == 4'd1 && p4 == 0) p4 = i;
      if (q16 == 16'd1 && p16 == 0) p16 = i;
    end
    chk("R8 period w3", 16'(p3), 16'd7);
    chk("R8 period w4", 16'(p4), 16'd15);
    chk("R8 period w16", 16'(p16), 16'd65535);
    chk("R8 zero unseen w3", 16'(cnt3[0]), 16'd0);
    chk("R8 zero unseen w4", 16'(cnt4[0]), 16'd0);
    for (int k = 1; k < 8; k++)  chk("R8 once w3", 16'(cnt3[k]), 16'd1);
    for (int k = 1; k < 16; k++) chk("R8 once w4", 16'(cnt4[k]), 16'd1);

    step(0, 1, 0, 16'h0);
    h3 = {13'b0, q3}; h4 = {12'b0, q4}; h16 = q16;
    step(0, 0, 0, 16'hFFFF);
    step(0, 0, 0, 16'h1234);
    chk("R7 hold w16", q16, h16);
    chk("R7 hold w4", {12'b0, q4}, h4);
    chk("R7 hold w3", {13'b0, q3}, h3);

    step(0, 1, 1, 16'h0);
    chk("R6 zero seed", q16, 16'h0);
    step(0, 0, 0, 16'h0);
    chk("R7 zero held", q16, 16'h0);
    step(0, 1, 0, 16'h0);
    chk("R4 exit w3", {13'b0, q3}, 16'd4);
    chk("R4 exit w4", {12'b0, q4}, 16'd8);
    chk("R4 exit w16", q16, 16'h8000);

    step(0, 0, 1, 16'hFFFF);
    step(0, 1, 0, 16'h0);
    chk("R5 ones w3", {13'b0, q3}, 16'd3);
    chk("R5 ones w4", {12'b0, q4}, 16'd7);
    chk("R5 ones w16", q16, 16'h7FFF);

    step(0, 1, 1, 16'hACE1);
    chk("R6 seed w16", q16, 16'hACE1);
    chk("R6 seed w3", {13'b0, q3}, 16'd1);
    for (int i = 0; i < 40; i++) step(0, (i % 3) != 0, 1'b0, 16'h0);

    step(1, 1, 1, 16'h1234);
    chk("R1 reset over load", q16, 16'd1);

    done = 1'b1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule